// File: doc/BRIEF.md
# Pixel Row Readout Sequencer

This block times the row-by-row readout of a pixel matrix. The gate and clear lines of the matrix run along rows and the pixel outputs run down columns. For each readout line, which is one row or an adjacent pair of rows, the sequencer switches the gate lines on and waits for the line to settle. It then tells the column electronics to take a first sample of signal plus pedestal. It pulses the clear lines of the same line and tells the column electronics to take a second sample of pedestal alone. Finally it switches the gate lines off again, so the readout can subtract the two samples as a correlated double sample.

The sequencer steps through the lines in ascending order and wraps back to row 0 after the last line. Each wrap is marked with a one-cycle pulse. The sequencer keeps cycling frames until it is told to stop. The length of each of the five phases comes from a small duration table. The table can be written only while the sequencer is idle. In pair mode two neighbouring rows are read together, which halves the number of lines per frame.

Top module: `pixel_row_sequencer`

## Requirements
- R1: After reset the sequencer is idle and every gate, clear, strobe, busy and frame_done output is low. Every duration entry resets to RST_DUR.
- R2: Each line runs through five phases in a fixed order. The table address of each phase is its position in that order: settle (0), sample-1 (1), clear (2), sample-2 (3), gap (4). Each phase lasts (entry + 1) cycles. The gate lines of the line are high during settle, sample-1, clear and sample-2, and low during the gap.
- R3: A clear line is high only during the clear phase, and only on a row whose gate line is high in that same cycle.
- R4: samp1_stb is high in exactly the cycles of the sample-1 phase, and samp2_stb in exactly the cycles of the sample-2 phase. The two strobes are never high together.
- R5: In single mode at most one gate line is high at a time. In pair mode at most rows 2k and 2k+1 are high together. row_idx reports the lower row of the active line while busy.
- R6: Lines advance by one row in single mode and by two rows in pair mode. After the last line the sequencer continues at row 0 with no idle cycle.
- R7: frame_done is high for exactly one cycle: the cycle after the gap of the last line of a frame ends.
- R8: A start seen while idle begins a frame at row 0 on the next cycle, and pair_mode is captured at that edge. A start or a pair_mode change while busy has no effect.
- R9: A stop seen while busy lets the current line finish, including its gap, and then the sequencer goes idle. A stop seen while idle has no effect.
- R10: A table write takes effect only while idle and only for addresses 0 to 4. A write while busy, or to addresses 5 to 7, leaves every duration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame when idle |
| stop | input | 1 | Halt after the current line |
| pair_mode | input | 1 | 1 = read two adjacent rows per line (captured at start) |
| wr_en | input | 1 | Duration table write enable |
| wr_addr | input | 3 | Duration table address (phase number) |
| wr_data | input | DUR_W | Duration value; phase lasts value + 1 cycles |
| gate_en | output | ROWS | Per-row gate enable |
| clear_en | output | ROWS | Per-row clear enable |
| samp1_stb | output | 1 | Capture the signal-plus-pedestal sample |
| samp2_stb | output | 1 | Capture the pedestal sample |
| row_idx | output | $clog2(ROWS) | Lower row of the active line |
| busy | output | 1 | Sequencer running |
| frame_done | output | 1 | One-cycle pulse at frame wrap |

## Verification
The bench builds the sequencer with ROWS = 8 and DUR_W = 3. With these values a full frame is only eight lines in single mode or four in pair mode, so several wraps and stops on the last line fit in a short run. Durations can span 0 to 7, so the bench covers zero-length-plus-one phases, the largest entry, and random mixes in between. Stops are placed both at the start of a line and in the final gap cycle. Ignored starts, table writes and pair_mode changes are placed inside running frames.

// File: rtl/rowseq_pkg.sv
// Shared definitions for the pixel row readout sequencer.
// Assumes the duration table address equals the phase position in the line.
package rowseq_pkg;
    localparam int N_TIMED = 5;
    localparam int ADDR_W  = 3;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETTLE = 3'd1,
        PH_SAMP1  = 3'd2,
        PH_CLEAR  = 3'd3,
        PH_SAMP2  = 3'd4,
        PH_GAP    = 3'd5
    } phase_e;
endpackage

// File: rtl/rowseq_timing_regs.sv
// Duration table: one entry per timed phase, written only while unlocked.
// Assumes lock is high whenever the sequencer is running.
module rowseq_timing_regs
    import rowseq_pkg::*;
#(
    parameter int DUR_W   = 4,
    parameter int RST_DUR = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lock,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DUR_W-1:0]           wr_data,
    output logic [N_TIMED*DUR_W-1:0]   dur_flat
);
    localparam logic [DUR_W-1:0] RST_VAL = DUR_W'(RST_DUR);

    for (genvar i = 0; i < N_TIMED; i++) begin : g_entry
        logic [DUR_W-1:0] entry_q;
        // Hold one phase duration; accept a write to this address when unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q <= RST_VAL;
            else if (wr_en && !lock && (wr_addr == ADDR_W'(i)))
                entry_q <= wr_data;
        end
        assign dur_flat[i*DUR_W +: DUR_W] = entry_q;
    end

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(dur_flat));
endmodule

// File: rtl/rowseq_phase_fsm.sv
// Phase state machine and down counter for one readout line.
// Each timed phase lasts its table entry plus one cycle; the gap end
// decides between the next line and idle, and flags frame wrap.
module rowseq_phase_fsm
    import rowseq_pkg::*;
#(
    parameter int DUR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     stop,
    input  logic                     pair_in,
    input  logic [N_TIMED*DUR_W-1:0] dur_flat,
    input  logic                     last_line,
    output phase_e                   phase,
    output logic                     pair_q,
    output logic                     busy,
    output logic                     line_begin,
    output logic                     line_step,
    output logic                     frame_done
);
    logic [DUR_W-1:0] dur_arr [N_TIMED];
    logic [DUR_W-1:0] cnt_q;
    logic [DUR_W-1:0] next_dur;
    logic             stop_pend_q;
    logic             phase_end;

    // Unpack the flat duration bus into per-phase entries.
    always_comb begin
        for (int i = 0; i < N_TIMED; i++)
            dur_arr[i] = dur_flat[i*DUR_W +: DUR_W];
    end

    // Pick the duration of the phase that follows the current one.
    always_comb begin
        case (phase)
            PH_SETTLE: next_dur = dur_arr[1];
            PH_SAMP1:  next_dur = dur_arr[2];
            PH_CLEAR:  next_dur = dur_arr[3];
            PH_SAMP2:  next_dur = dur_arr[4];
            default:   next_dur = dur_arr[0];
        endcase
    end

    assign busy       = (phase != PH_IDLE);
    assign phase_end  = busy && (cnt_q == '0);
    assign line_begin = (phase == PH_IDLE) && start;
    assign line_step  = phase_end && (phase == PH_GAP);

    // Advance phases, count durations, latch stop requests and flag wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            cnt_q       <= '0;
            stop_pend_q <= 1'b0;
            frame_done  <= 1'b0;
            pair_q      <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (phase == PH_IDLE) begin
                stop_pend_q <= 1'b0;
                if (start) begin
                    phase  <= PH_SETTLE;
                    cnt_q  <= dur_arr[0];
                    pair_q <= pair_in;
                end
            end else begin
                if (stop)
                    stop_pend_q <= 1'b1;
                if (!phase_end) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (phase != PH_GAP) begin
                    phase <= phase_e'(phase + 3'd1);
                    cnt_q <= next_dur;
                end else begin
                    frame_done <= last_line;
                    if (stop_pend_q || stop) begin
                        phase <= PH_IDLE;
                    end else begin
                        phase <= PH_SETTLE;
                        cnt_q <= next_dur;
                    end
                end
            end
        end
    end

    // R2
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (phase != $past(phase))) |->
        ((phase == phase_e'($past(phase) + 3'd1)) ||
         (phase == PH_SETTLE && $past(phase) == PH_GAP)));

    // R7
    frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pair_q));
endmodule

// File: rtl/rowseq_row_counter.sv
// Line counter: holds the lower row of the active line, steps by one or
// two rows, and wraps to row 0 after the last line.
// Assumes ROWS is even so that pair mode lands exactly on ROWS-2.
module rowseq_row_counter #(
    parameter int ROWS = 64,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    input  logic          pair,
    output logic [RW-1:0] row_idx,
    output logic          last_line
);
    localparam logic [RW-1:0] LAST_ONE  = RW'(ROWS - 1);
    localparam logic [RW-1:0] LAST_PAIR = RW'(ROWS - 2);

    logic [RW-1:0] incr;

    assign last_line = pair ? (row_idx == LAST_PAIR) : (row_idx == LAST_ONE);
    assign incr      = pair ? RW'(2) : RW'(1);

    // Reset to row 0 on a new frame, otherwise advance or wrap at line end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            row_idx <= '0;
        else if (step)
            row_idx <= last_line ? '0 : row_idx + incr;
    end

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last_line) |=> (row_idx == '0));

    // R6
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last_line && !restart) |=> (row_idx > $past(row_idx)));
endmodule

// File: rtl/rowseq_line_decode.sv
// Turns the active line and phase into per-row gate and clear enables
// and the two sample strobes. Assumes row_idx is even in pair mode.
module rowseq_line_decode
    import rowseq_pkg::*;
#(
    parameter int ROWS = 64,
    localparam int RW  = $clog2(ROWS)
) (
    input  phase_e          phase,
    input  logic [RW-1:0]   row_idx,
    input  logic            pair,
    input  logic            clk,
    input  logic            rst_n,
    output logic [ROWS-1:0] gate_en,
    output logic [ROWS-1:0] clear_en,
    output logic            samp1_stb,
    output logic            samp2_stb
);
    logic gate_on;
    logic clear_on;

    assign gate_on   = (phase == PH_SETTLE) || (phase == PH_SAMP1) ||
                       (phase == PH_CLEAR)  || (phase == PH_SAMP2);
    assign clear_on  = (phase == PH_CLEAR);
    assign samp1_stb = (phase == PH_SAMP1);
    assign samp2_stb = (phase == PH_SAMP2);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic sel;
        if (r % 2 == 1) begin : g_odd
            assign sel = (row_idx == RW'(r)) || (pair && (row_idx == RW'(r - 1)));
        end else begin : g_even
            assign sel = (row_idx == RW'(r));
        end
        assign gate_en[r]  = sel && gate_on;
        assign clear_en[r] = sel && clear_on;
    end

    // R5
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gate_en) <= (pair ? 2 : 1));

    // R3
    clear_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_en & ~gate_en) == '0);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp1_stb && samp2_stb));

    // R4
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp1_stb || samp2_stb) |-> ((gate_en != '0) && (clear_en == '0)));
endmodule

// File: rtl/pixel_row_sequencer.sv
// Top of the pixel row readout sequencer. Ties the duration table, the
// phase machine, the line counter and the row decode together.
// Assumes ROWS is even and at least 2.
module pixel_row_sequencer
    import rowseq_pkg::*;
#(
    parameter int ROWS    = 64,
    parameter int DUR_W   = 4,
    parameter int RST_DUR = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     stop,
    input  logic                     pair_mode,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DUR_W-1:0]         wr_data,
    output logic [ROWS-1:0]          gate_en,
    output logic [ROWS-1:0]          clear_en,
    output logic                     samp1_stb,
    output logic                     samp2_stb,
    output logic [$clog2(ROWS)-1:0]  row_idx,
    output logic                     busy,
    output logic                     frame_done
);
    logic [N_TIMED*DUR_W-1:0] dur_flat;
    phase_e                   phase;
    logic                     pair_q;
    logic                     line_begin;
    logic                     line_step;
    logic                     last_line;

    rowseq_timing_regs #(.DUR_W(DUR_W), .RST_DUR(RST_DUR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (busy),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .dur_flat (dur_flat)
    );

    rowseq_phase_fsm #(.DUR_W(DUR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .pair_in    (pair_mode),
        .dur_flat   (dur_flat),
        .last_line  (last_line),
        .phase      (phase),
        .pair_q     (pair_q),
        .busy       (busy),
        .line_begin (line_begin),
        .line_step  (line_step),
        .frame_done (frame_done)
    );

    rowseq_row_counter #(.ROWS(ROWS)) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (line_begin),
        .step      (line_step),
        .pair      (pair_q),
        .row_idx   (row_idx),
        .last_line (last_line)
    );

    rowseq_line_decode #(.ROWS(ROWS)) u_dec (
        .phase     (phase),
        .row_idx   (row_idx),
        .pair      (pair_q),
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_en   (gate_en),
        .clear_en  (clear_en),
        .samp1_stb (samp1_stb),
        .samp2_stb (samp2_stb)
    );

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((gate_en == '0) && (clear_en == '0) && !samp1_stb && !samp2_stb));

    // R7
    done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(busy));
endmodule

// File: tb/test_pixel_row_sequencer.sv
// Self-checking bench: per-cycle expected outputs from a phase-walk model.
module test_pixel_row_sequencer;
    localparam int ROWS  = 8;
    localparam int DUR_W = 3;
    localparam int RW    = $clog2(ROWS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             stop = 1'b0;
    logic             pair_mode = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [DUR_W-1:0] wr_data = '0;
    logic [ROWS-1:0]  gate_en;
    logic [ROWS-1:0]  clear_en;
    logic             samp1_stb;
    logic             samp2_stb;
    logic [RW-1:0]    row_idx;
    logic             busy;
    logic             frame_done;

    int n_cmp = 0;
    int n_bad = 0;
    int mdur [5];

    pixel_row_sequencer #(.ROWS(ROWS), .DUR_W(DUR_W), .RST_DUR(1)) i_pixel_row_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .pair_mode(pair_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gate_en(gate_en), .clear_en(clear_en), .samp1_stb(samp1_stb),
        .samp2_stb(samp2_stb), .row_idx(row_idx), .busy(busy), .frame_done(frame_done)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ROWS-1:0] line_mask(input int row, input bit pair);
        logic [ROWS-1:0] m = '0;
        m[row] = 1'b1;
        if (pair) m[row + 1] = 1'b1;
        return m;
    endfunction

    task automatic write_dur(input int addr, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(addr); wr_data = DUR_W'(val);
        @(negedge clk);
        wr_en = 1'b0;
        if (addr < 5) mdur[addr] = val;
    endtask

    task automatic check_idle(input bit fd_exp);
        chk("R9 busy idle", 64'(busy), 64'd0);
        chk("R9 gate idle", 64'(gate_en), 64'd0);
        chk("R9 clear idle", 64'(clear_en), 64'd0);
        chk("R7 frame_done idle", 64'(frame_done), 64'(fd_exp));
    endtask

    // Start a run, walk every cycle of every line, stop in line stop_line.
    task automatic run_lines(input bit pair, input int stop_line, input bit late, input bit poke);
        int nlines = pair ? ROWS / 2 : ROWS;
        bit fd_exp = 1'b0;
        @(negedge clk);
        start = 1'b1; pair_mode = pair;
        @(negedge clk);
        start = 1'b0; pair_mode = ~pair;  // R8: change after capture is ignored
        for (int ln = 0; ln <= stop_line; ln++) begin
            int row = (ln % nlines) * (pair ? 2 : 1);
            for (int p = 0; p < 5; p++) begin
                for (int c = 0; c <= mdur[p]; c++) begin
                    logic [ROWS-1:0] m = line_mask(row, pair);
                    chk("R8 busy", 64'(busy), 64'd1);
                    chk("R2 gate", 64'(gate_en), (p < 4) ? 64'(m) : 64'd0);
                    chk("R3 clear", 64'(clear_en), (p == 2) ? 64'(m) : 64'd0);
                    chk("R4 samp1", 64'(samp1_stb), 64'(p == 1));
                    chk("R4 samp2", 64'(samp2_stb), 64'(p == 3));
                    chk("R5 row_idx", 64'(row_idx), 64'(row));
                    chk("R7 frame_done", 64'(frame_done), 64'(fd_exp));
                    fd_exp = 1'b0;
                    stop  = (ln == stop_line) &&
                            (late ? (p == 4 && c == mdur[4]) : (p == 0 && c == 0));
                    wr_en = poke && ln == 0 && p == 0 && c == 0;  // R10: busy write
                    start = poke && ln == 0 && p == 0 && c == 0;  // R8: busy start
                    wr_addr = 3'($urandom_range(0, 4));
                    wr_data = DUR_W'($urandom_range(0, 7));
                    @(negedge clk);
                end
            end
            fd_exp = ((ln % nlines) == nlines - 1);  // R6/R7 wrap
        end
        stop = 1'b0; wr_en = 1'b0; start = 1'b0;
        check_idle(fd_exp);
        @(negedge clk);
        check_idle(1'b0);
    endtask

    initial begin
        int seed_junk = $urandom(1234);
        for (int i = 0; i < 5; i++) mdur[i] = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 gate", 64'(gate_en), 64'd0);
        chk("R1 clear", 64'(clear_en), 64'd0);
        chk("R1 strobes", 64'({samp1_stb, samp2_stb}), 64'd0);
        chk("R1 frame_done", 64'(frame_done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset durations, single mode with wrap (R6)
        run_lines(1'b0, 9, 1'b0, 1'b0);
        // R9: stop while idle ignored, then a full frame plus wrap
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        check_idle(1'b0);
        for (int i = 0; i < 5; i++) write_dur(i, 0);
        run_lines(1'b1, 5, 1'b1, 1'b1);
        // R2: largest entry on clear phase, R10: address 5 ignored
        write_dur(2, 7);
        write_dur(5, 3);
        run_lines(1'b0, 7, 1'b1, 1'b1);  // stop in last line of frame
        run_lines(1'b1, 3, 1'b0, 1'b0);  // pair, stop in last line
        // constrained random mix
        for (int it = 0; it < 14; it++) begin
            for (int i = 0; i < 5; i++) write_dur(i, $urandom_range(0, 3));
            run_lines(1'($urandom_range(0, 1)), $urandom_range(0, 11),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule